// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the target end of a two-wire serial management bus of the clause-22 kind. A host toggles the management clock and data lines. The block samples both lines through the system clock and picks out edges of the management clock. It waits for a long run of preamble ones and then decodes a frame: a start pair, a two-bit opcode, a five-bit PHY address, a five-bit register address and a two-bit turnaround. After that it either takes in sixteen write bits or sends out sixteen read bits.

Register contents come from an attached PHY register set through a simple port. The read is combinational: the block raises a one-cycle read strobe with the register address and takes the data in the same cycle. A write is handed over as a one-cycle write strobe with address and data. The block answers only for the PHY address set by a parameter, which is 1 by default. For any other address it stays off the line, so the pull-up makes a read return all ones. Tristate control is reduced to an output enable and an output bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset the output enable is 0, the output bit is 1 (idle level), and the read strobe, write strobe and start-error flag are all 0.
- R2: A frame is accepted only after at least 32 rising edges of the management clock have been seen since reset or since the end of the last frame. The frame then begins at the next rising edge where the data line is 0. With fewer than 32 rising edges, a 0 does not start a frame.
- R3: The opcode, PHY address and register address are taken on rising edges, most significant bit first. The register address presented on the register port equals the five register bits that were sent.
- R4: A read (opcode 2'b10) to the block's own PHY address gives exactly one read-strobe pulse, at the second turnaround rising edge. The output enable is raised at that same edge, with the output bit at 0 for the rest of that clock period.
- R5: Read data goes out most significant bit first. Each new bit appears after a falling edge of the management clock, so bit 15 appears after the first falling edge that follows the turnaround. The output bit holds steady while the clock is high.
- R6: A write (opcode 2'b01) to the own address samples 16 data bits on rising edges, most significant bit first. It gives exactly one write-strobe pulse after the 16th data bit, carrying the register address and the 16-bit value.
- R7: After the 16th data rising edge the block drops the output enable, puts the output bit back to 1 and goes back to waiting for preamble. A second frame needs its own 32 preamble edges.
- R8: For a PHY address that differs from the block's own, a read leaves the output enable at 0, so the line reads 0xFFFF through the pull-up, and gives no read strobe. A write to that address gives no write strobe and leaves the own register contents unchanged.
- R9: Opcodes 2'b00 and 2'b11 give no read strobe, no write strobe and no drive, even when sent to the own address.
- R10: If the second start bit is sampled as 0 instead of 1, the start-error output pulses high for one system clock. The frame still goes on to complete normally.
- R11: The answering PHY address is a parameter whose default value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mdcIn | input | 1 | Management clock from the host, asynchronous |
| mdioIn | input | 1 | Management data line as seen at the pin |
| mdioOut | output | 1 | Data bit driven when the enable is high |
| mdioOe | output | 1 | Drive enable for the data line |
| regRdEn | output | 1 | One-cycle read strobe to the register set |
| regWrEn | output | 1 | One-cycle write strobe to the register set |
| regAddr | output | 5 | Register address of the current frame |
| regWrData | output | 16 | Write value that goes with regWrEn |
| regRdData | input | 16 | Register value, read in the cycle of regRdEn |
| startErr | output | 1 | One-cycle pulse when the second start bit is wrong |

## Verification
The bench sends whole frames and checks the line against a behavioural model in every half period of the management clock. Reads and writes to the own address with different values show that the fields are taken MSB first and that data goes out on falling edges. Frames sent to a foreign address, and frames with the two unused opcodes, show that the block neither drives nor strobes for them. A second read after a write shows whether a write was really dropped or really committed. Preambles that are long, exactly 32 edges, and too short check the entry rule, and a frame with a bad start bit shows that the error flag pulses while the frame still completes.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  localparam int OP_W   = 2;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int TA_LEN = 2;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    StPre, StStart, StOp, StPhy, StReg, StTurn, StData
  } mdioState_t;

  typedef struct packed {
    logic hdrShift;
    logic dataShiftIn;
    logic dataLoad;
    logic shiftOut;
    logic driveOn;
    logic driveOff;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_sync_edge.sv
module mdio_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdcIn,
  input  logic mdioIn,
  output logic mdcRise,
  output logic mdcFall,
  output logic mdioBit
);
  logic [STAGES-1:0] mdcPipe;
  logic [STAGES-1:0] mdioPipe;
  logic mdcLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcPipe  <= '0;
      mdioPipe <= '1;
      mdcLast  <= 1'b0;
    end else begin
      mdcPipe[0]  <= mdcIn;
      mdioPipe[0] <= mdioIn;
      for (int i = 1; i < STAGES; i++) begin
        mdcPipe[i]  <= mdcPipe[i-1];
        mdioPipe[i] <= mdioPipe[i-1];
      end
      mdcLast <= mdcPipe[STAGES-1];
    end
  end

  assign mdcRise = mdcPipe[STAGES-1] & ~mdcLast;
  assign mdcFall = ~mdcPipe[STAGES-1] & mdcLast;
  assign mdioBit = mdioPipe[STAGES-1];
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_slv_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mdcRise,
  input  logic        mdcFall,
  input  logic        mdioBit,
  input  logic        isRead,
  input  logic        isWrite,
  input  logic        addrMatch,
  output mdioStrobe_t stb,
  output logic        regWrEn,
  output logic        startErr
);
  localparam int CNT_MAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  mdioState_t state;
  logic [CNT_W-1:0] cnt;
  logic readActive;
  logic lastTurn;
  logic lastData;

  assign lastTurn = (state == StTurn) && (cnt == CNT_W'(TA_LEN - 1));
  assign lastData = (state == StData) && (cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= StPre;
      cnt        <= '0;
      readActive <= 1'b0;
      regWrEn    <= 1'b0;
      startErr   <= 1'b0;
    end else begin
      regWrEn  <= 1'b0;
      startErr <= 1'b0;
      if (mdcRise) begin
        unique case (state)
          StPre: begin
            if (cnt >= CNT_W'(PRE_LEN) && !mdioBit) begin
              state <= StStart;
              cnt   <= '0;
            end else if (cnt < CNT_W'(PRE_LEN)) begin
              cnt <= cnt + 1'b1;
            end
          end
          StStart: begin
            if (!mdioBit) startErr <= 1'b1;
            state <= StOp;
            cnt   <= '0;
          end
          StOp: begin
            if (cnt == CNT_W'(OP_W - 1)) begin
              state <= StPhy;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          StPhy: begin
            if (cnt == CNT_W'(PHY_W - 1)) begin
              state <= StReg;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          StReg: begin
            if (cnt == CNT_W'(REG_W - 1)) begin
              state <= StTurn;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          StTurn: begin
            if (lastTurn) begin
              state      <= StData;
              cnt        <= '0;
              readActive <= isRead && addrMatch;
            end else cnt <= cnt + 1'b1;
          end
          StData: begin
            if (lastData) begin
              state      <= StPre;
              cnt        <= '0;
              readActive <= 1'b0;
              regWrEn    <= isWrite && addrMatch;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= StPre;
        endcase
      end
    end
  end

  always_comb begin
    stb             = '0;
    stb.hdrShift    = mdcRise && (state == StOp || state == StPhy || state == StReg);
    stb.dataShiftIn = mdcRise && (state == StData) && !readActive;
    stb.dataLoad    = mdcRise && lastTurn && isRead && addrMatch;
    stb.driveOn     = stb.dataLoad;
    stb.shiftOut    = mdcFall && (state == StData) && readActive;
    stb.driveOff    = mdcRise && lastData && readActive;
  end

  // R2: too few preamble edges keep the decoder waiting
  assert_pre_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == StPre && mdcRise && cnt < CNT_W'(PRE_LEN)) |=> (state == StPre));

  // R6 and R7: the commit strobe coincides with the return to preamble
  assert_commit_at_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (state == StPre && !readActive));

  // R10: start error is a single-cycle pulse
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    startErr |=> !startErr);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_slv_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdioBit,
  input  mdioStrobe_t       stb,
  input  logic [DATA_W-1:0] regRdData,
  output logic              isRead,
  output logic              isWrite,
  output logic              addrMatch,
  output logic [REG_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam int HDR_W = OP_W + PHY_W + REG_W;

  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] dataSr;
  logic [OP_W-1:0]   opField;
  logic [PHY_W-1:0]  phyField;

  assign opField   = hdr[HDR_W-1 -: OP_W];
  assign phyField  = hdr[REG_W +: PHY_W];
  assign regAddr   = hdr[0 +: REG_W];
  assign isRead    = (opField == OP_READ);
  assign isWrite   = (opField == OP_WRITE);
  assign addrMatch = (phyField == PHY_W'(PHY_ADDR));
  assign regWrData = dataSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdr     <= '0;
      dataSr  <= '0;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else begin
      if (stb.hdrShift) hdr <= {hdr[HDR_W-2:0], mdioBit};
      if (stb.dataLoad) dataSr <= regRdData;
      else if (stb.dataShiftIn) dataSr <= {dataSr[DATA_W-2:0], mdioBit};
      else if (stb.shiftOut) dataSr <= {dataSr[DATA_W-2:0], 1'b0};
      if (stb.driveOn) begin
        mdioOe  <= 1'b1;
        mdioOut <= 1'b0;
      end else if (stb.driveOff) begin
        mdioOe  <= 1'b0;
        mdioOut <= 1'b1;
      end else if (stb.shiftOut) begin
        mdioOut <= dataSr[DATA_W-1];
      end
    end
  end

  // R4: fetching read data turns the driver on
  assert_load_drives_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataLoad |=> mdioOe);

  // R5: while driving, the bit only moves on a falling-edge shift
  assert_out_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && !stb.shiftOut && !stb.driveOff) |=> $stable(mdioOut));

  // R7: a released line sits at the idle level
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdioOe) |-> mdioOut);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int PHY_ADDR    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LEN     = 32,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdcIn,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              regRdEn,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              startErr
);
  logic mdcRise, mdcFall, mdioBit;
  logic isRead, isWrite, addrMatch;
  mdioStrobe_t stb;

  mdio_sync_edge #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .mdcIn(mdcIn), .mdioIn(mdioIn),
    .mdcRise(mdcRise), .mdcFall(mdcFall), .mdioBit(mdioBit)
  );

  mdio_ctrl #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mdcRise(mdcRise), .mdcFall(mdcFall),
    .mdioBit(mdioBit), .isRead(isRead), .isWrite(isWrite),
    .addrMatch(addrMatch), .stb(stb), .regWrEn(regWrEn), .startErr(startErr)
  );

  mdio_dp #(.PHY_ADDR(PHY_ADDR), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .mdioBit(mdioBit), .stb(stb),
    .regRdData(regRdData), .isRead(isRead), .isWrite(isWrite),
    .addrMatch(addrMatch), .regAddr(regAddr), .regWrData(regWrData),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  assign regRdEn = stb.dataLoad;
endmodule

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
  localparam int HALF   = 8;
  localparam int SETTLE = 4;
  localparam logic [4:0] OWN = 5'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdcIn = 1'b0;
  logic masterMdio = 1'b1;
  logic masterDrive = 1'b1;
  logic mdioIn, mdioOut, mdioOe, regRdEn, regWrEn, startErr;
  logic [4:0]  regAddr;
  logic [15:0] regWrData, regRdData;

  logic [15:0] phyMem [32];
  logic [15:0] model  [32];
  int tests = 0, fails = 0;
  int rdCount = 0, wrCount = 0, errCount = 0;
  logic [4:0]  lastWrAddr;
  logic [15:0] lastWrData;
  logic expOe = 1'b0, expOut = 1'b1;
  bit done = 0;

  always #5 clk = ~clk;

  assign mdioIn = masterDrive ? masterMdio : (mdioOe ? mdioOut : 1'b1);
  assign regRdData = phyMem[regAddr];

  mdio_mgmt_slave dut (
    .clk(clk), .rstN(rstN), .mdcIn(mdcIn), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .startErr(startErr)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (regRdEn) rdCount <= rdCount + 1;
      if (startErr) errCount <= errCount + 1;
      if (regWrEn) begin
        wrCount <= wrCount + 1;
        phyMem[regAddr] <= regWrData;
        lastWrAddr <= regAddr;
        lastWrData <= regWrData;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic halfWait(input string req);
    bit bad = 0;
    int aOe = 0, aOut = 0;
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      if (i >= SETTLE && (mdioOe !== expOe || mdioOut !== expOut)) begin
        bad = 1; aOe = mdioOe; aOut = mdioOut;
      end
    end
    chk(!bad, req, "line oe*2+out", aOe * 2 + aOut, expOe * 2 + expOut);
  endtask

  task automatic bitCycle(input logic b, input logic drv,
                          input logic oeH, input logic outH,
                          input logic oeL, input logic outL, input string req);
    masterMdio = b; masterDrive = drv;
    mdcIn = 1'b1; expOe = oeH; expOut = outH;
    halfWait(req);
    mdcIn = 1'b0; expOe = oeL; expOut = outL;
    halfWait(req);
  endtask

  task automatic frame(input int preN, input logic s2, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input string req);
    bit own = (op == 2'b10) && (phy == OWN);
    bit rdOp = (op == 2'b10);
    logic [15:0] rv = model[rg];
    for (int i = 0; i < preN; i++) bitCycle(1'b1, 1'b1, 0, 1, 0, 1, req);
    bitCycle(1'b0, 1'b1, 0, 1, 0, 1, req);
    bitCycle(s2, 1'b1, 0, 1, 0, 1, req);
    for (int i = 1; i >= 0; i--) bitCycle(op[i], 1'b1, 0, 1, 0, 1, req);
    for (int i = 4; i >= 0; i--) bitCycle(phy[i], 1'b1, 0, 1, 0, 1, req);
    for (int i = 4; i >= 0; i--) bitCycle(rg[i], 1'b1, 0, 1, 0, 1, req);
    bitCycle(1'b1, !rdOp, 0, 1, 0, 1, req);
    if (own) bitCycle(1'b0, 1'b0, 1, 0, 1, rv[15], req);
    else     bitCycle(1'b0, !rdOp, 0, 1, 0, 1, req);
    for (int k = 0; k < 16; k++) begin
      logic b = rdOp ? 1'b1 : wd[15-k];
      if (own && k < 15) bitCycle(b, 1'b0, 1, rv[15-k], 1, rv[14-k], req);
      else bitCycle(b, !rdOp, 0, 1, 0, 1, req);
    end
    masterDrive = 1'b1; masterMdio = 1'b1;
    if (op == 2'b01 && phy == OWN) model[rg] = wd;
  endtask

  task automatic doReset();
    rstN = 1'b0; mdcIn = 1'b0; masterDrive = 1'b1; masterMdio = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int r0, w0, e0;
    for (int i = 0; i < 32; i++) begin
      phyMem[i] = 16'((i * 16'h1357) ^ 16'hA05F);
      model[i]  = phyMem[i];
    end
    doReset();
    // R1: idle outputs after reset
    chk(mdioOe === 1'b0, "R1", "oe after reset", mdioOe, 0);
    chk(mdioOut === 1'b1, "R1", "out after reset", mdioOut, 1);
    chk(!regRdEn && !regWrEn && !startErr, "R1", "strobes after reset",
        {regRdEn, regWrEn, startErr}, 0);

    // R2 R3 R4 R5 R11: read own default address after exactly 32 preamble edges
    r0 = rdCount;
    frame(32, 1'b1, 2'b10, OWN, 5'd2, 16'h0, "R5");
    chk(rdCount - r0 == 1, "R4", "read strobes", rdCount - r0, 1);

    // R6 R3: write own register
    w0 = wrCount;
    frame(32, 1'b1, 2'b01, OWN, 5'd4, 16'hA5C3, "R6");
    chk(wrCount - w0 == 1, "R6", "write strobes", wrCount - w0, 1);
    chk(lastWrAddr == 5'd4, "R3", "write address", lastWrAddr, 4);
    chk(lastWrData == 16'hA5C3, "R6", "write data", lastWrData, 16'hA5C3);

    // R7: back-to-back frame reads back the written value
    frame(32, 1'b1, 2'b10, OWN, 5'd4, 16'h0, "R7");
    frame(32, 1'b1, 2'b10, OWN, 5'd0, 16'h0, "R7");

    // R8: foreign address read and write
    r0 = rdCount; w0 = wrCount;
    frame(32, 1'b1, 2'b10, 5'd3, 5'd2, 16'h0, "R8");
    frame(32, 1'b1, 2'b01, 5'd0, 5'd4, 16'h1111, "R8");
    chk(rdCount == r0, "R8", "foreign read strobe", rdCount - r0, 0);
    chk(wrCount == w0, "R8", "foreign write strobe", wrCount - w0, 0);
    frame(32, 1'b1, 2'b10, OWN, 5'd4, 16'h0, "R8");

    // R9: unused opcodes to own address
    r0 = rdCount; w0 = wrCount;
    frame(32, 1'b1, 2'b00, OWN, 5'd4, 16'h1234, "R9");
    frame(32, 1'b1, 2'b11, OWN, 5'd4, 16'h4321, "R9");
    chk(rdCount == r0, "R9", "read strobe", rdCount - r0, 0);
    chk(wrCount == w0, "R9", "write strobe", wrCount - w0, 0);
    frame(32, 1'b1, 2'b10, OWN, 5'd4, 16'h0, "R9");

    // R10: bad second start bit flags and the read still completes
    e0 = errCount; r0 = rdCount;
    frame(32, 1'b0, 2'b10, OWN, 5'd7, 16'h0, "R10");
    chk(errCount - e0 == 1, "R10", "start error pulses", errCount - e0, 1);
    chk(rdCount - r0 == 1, "R10", "read after bad start", rdCount - r0, 1);
    e0 = errCount;
    frame(32, 1'b1, 2'b10, OWN, 5'd7, 16'h0, "R10");
    chk(errCount == e0, "R10", "no flag on good start", errCount - e0, 0);

    // R2: long preamble accepted
    frame(45, 1'b1, 2'b10, OWN, 5'd9, 16'h0, "R2");

    // R2: short preamble after reset is not accepted
    doReset();
    r0 = rdCount;
    frame(20, 1'b1, 2'b01, 5'd31, 5'd31, 16'hFFFF, "R2");
    for (int i = 0; i < 18; i++) bitCycle(1'b1, 1'b1, 0, 1, 0, 1, "R2");
    chk(rdCount == r0 && wrCount == w0, "R2", "strobes on short preamble",
        rdCount - r0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule